// File: doc/BRIEF.md
# Double-Rate Data Gearbox for a DRAM Data Bus

This block sits between a single-rate user data bus and a double-data-rate memory data bus. On the write side it takes one 128-bit word per core clock and sends it out as two 64-bit beats on one data-bus cycle, the low half first. The data strobes it drives change in the middle of each beat, with a low preamble before a burst and a low postamble after it. On the read side it takes two 64-bit beats per core cycle from the bus and joins them into one 128-bit word. It hands that word to the core clock domain with a valid flag.

The double-rate side is built on a second clock at twice the core frequency. That clock has rising edges aligned with the core clock. A controller supplies per-byte-lane write enables, per-slice read enables and a read data-valid enable. A burst of four beats moves two user words. The pad cells, delay lines and calibration sit outside this block. The block gives an output-enable per byte lane and per strobe, and takes a separate input copy of the data bus.

Top module: `ddr_gearbox`

## Requirements
- R1: While reset is held, `dq_oe`, `dqs_oe`, `dqs_out`, `u_rvalid` and `u_rdata` are all zero.
- R2: A word on `u_wdata` in core cycle n with a nonzero `wr_lane_en` goes onto `dq_out` in cycle n+2. Bits [63:0] are driven in the first half of that cycle and bits [127:64] in the second half.
- R3: `dq_oe[k]`, the enable for bits [8k+7:8k], equals `wr_lane_en[k]` from two core cycles earlier. It is zero when no lane was enabled.
- R4: In a data cycle, strobe j covers lanes 4j to 4j+3. If any of those lanes is enabled, strobe j rises a quarter cycle in and falls three quarters in, centred on each beat. Otherwise it stays low.
- R5: `dqs_oe[j]` is high with strobe j low in the cycle before the first data cycle of a burst (preamble) and in the cycle after the last one (postamble). It is zero at all other times outside a burst.
- R6: The beat on `dq_in` in the first half of core cycle n becomes `u_rdata[63:0]`, and the second-half beat becomes `u_rdata[127:64]`. Both are visible from the start of cycle n+1.
- R7: `u_rvalid` is high in cycle n+1 exactly when `rd_dv_en` is high and `rd_slice_en` is nonzero in cycle n. A read burst with enables held for two cycles gives exactly two consecutive valid cycles.
- R8: If `rd_slice_en[s]` is clear, bits [16s+15:16s] of both beats read as zero in the delivered word.
- R9: `u_rdata` keeps its value in every cycle in which `u_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| clk2x | input | 1 | Double-frequency clock, rising edges aligned with `clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_wdata | input | 128 | User write word |
| wr_lane_en | input | 8 | Per-byte-lane write enable for this word |
| dq_out | output | 64 | Outgoing data beats |
| dq_oe | output | 8 | Per-byte-lane output enable for `dq_out` |
| dqs_out | output | 2 | Outgoing data strobes |
| dqs_oe | output | 2 | Per-strobe output enable |
| dq_in | input | 64 | Incoming data beats |
| rd_slice_en | input | 4 | Per-16-bit-slice read capture enable |
| rd_dv_en | input | 1 | Read data-valid enable |
| u_rdata | output | 128 | Reassembled read word |
| u_rvalid | output | 1 | Read word valid |

## Verification
The assertions assume the following about the inputs. The two clocks keep their fixed 2:1 rising-edge alignment from reset on. The read enables and `dq_in` change only between clock edges. The read data-valid enable is low during and right after reset. The bench makes both clocks in one process with the same blocking assignments. It drives all inputs one time unit after a core edge, or after the mid-cycle edge for the second read beat, and keeps every enable at zero until reset is released. Random write bursts are looped back through a model that captures on the strobe edges. The bench then replays the captured beats into the read side, and each rebuilt word must match the word that was sent.

// File: rtl/ddr_gb_pkg.sv
package ddr_gb_pkg;
  localparam int GB_USER_W  = 128;
  localparam int GB_STROBES = 2;
  localparam int GB_SLICES  = 4;
  localparam int GB_LANE_W  = 8;
endpackage

// File: rtl/ddr_gb_phase.sv
module ddr_gb_phase (
  input  logic clk,
  input  logic clk2x,
  input  logic rst_n,
  output logic hi_half
);
  // core-domain toggle, re-sampled on every fast edge; equal values mean
  // the current fast period is the second half of the core cycle
  logic core_tog;
  logic fast_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_tog <= 1'b0;
    else        core_tog <= ~core_tog;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) fast_seen <= 1'b0;
    else        fast_seen <= core_tog;
  end

  assign hi_half = (core_tog == fast_seen);
endmodule

// File: rtl/ddr_gb_wr.sv
module ddr_gb_wr
  import ddr_gb_pkg::*;
#(
  parameter  int UW    = GB_USER_W,
  parameter  int NSTRB = GB_STROBES,
  localparam int DW    = UW / 2,
  localparam int NLANE = DW / GB_LANE_W,
  localparam int LPS   = NLANE / NSTRB
) (
  input  logic             clk,
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             hi_half,
  input  logic [NLANE-1:0] lane_en,
  input  logic [UW-1:0]    wdata,
  output logic [DW-1:0]    dq_out,
  output logic [NLANE-1:0] dq_oe,
  output logic [NSTRB-1:0] dqs_out,
  output logic [NSTRB-1:0] dqs_oe
);
  function automatic logic [DW-1:0] beat_of(input logic [UW-1:0] w, input logic upper);
    return upper ? w[DW +: DW] : w[0 +: DW];
  endfunction

  function automatic logic group_any(input logic [NLANE-1:0] en, input int g);
    return en[g*LPS +: LPS] != '0;
  endfunction

  // stage 1: preamble cycle, stage 2: data cycle, stage 3: postamble cycle
  logic [NLANE-1:0] en_pre, en_dat, en_post;
  logic [UW-1:0]    word_pre, word_dat;
  logic [NSTRB-1:0] dqs_q;
  logic [NLANE-1:0] strobe_window;
  logic             burst_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pre   <= '0;
      en_dat   <= '0;
      en_post  <= '0;
      word_pre <= '0;
      word_dat <= '0;
    end else begin
      en_pre   <= lane_en;
      word_pre <= wdata;
      en_dat   <= en_pre;
      word_dat <= word_pre;
      en_post  <= en_dat;
    end
  end

  assign dq_out        = beat_of(word_dat, hi_half);
  assign dq_oe         = en_dat;
  assign strobe_window = en_pre | en_dat | en_post;
  assign burst_live    = (en_dat != '0);

  // strobe registered on the falling fast edge: quarter-cycle shift from data
  always_ff @(negedge clk2x or negedge rst_n) begin
    if (!rst_n) dqs_q <= '0;
    else begin
      for (int g = 0; g < NSTRB; g++)
        dqs_q[g] <= group_any(en_dat, g) && !hi_half;
    end
  end

  assign dqs_out = dqs_q;

  for (genvar g = 0; g < NSTRB; g++) begin : g_strobe
    assign dqs_oe[g] = group_any(strobe_window, g);

    // R4
    dqs_data_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
      dqs_out[g] |-> (dq_oe[g*LPS +: LPS] != '0));
  end

  // R3
  oe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_live |-> (dq_oe == $past(lane_en, 2)));

  // R5
  strobe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_live |-> (dqs_oe != '0));
endmodule

// File: rtl/ddr_gb_rd.sv
module ddr_gb_rd
  import ddr_gb_pkg::*;
#(
  parameter  int UW     = GB_USER_W,
  parameter  int NSLICE = GB_SLICES,
  localparam int DW     = UW / 2,
  localparam int SW     = DW / NSLICE
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              hi_half,
  input  logic [DW-1:0]     dq_in,
  input  logic [NSLICE-1:0] rd_en,
  input  logic              dv_en,
  output logic [UW-1:0]     u_rdata,
  output logic              u_rvalid
);
  function automatic logic [DW-1:0] slice_mask(input logic [NSLICE-1:0] en);
    logic [DW-1:0] m;
    for (int s = 0; s < NSLICE; s++) m[s*SW +: SW] = {SW{en[s]}};
    return m;
  endfunction

  logic [DW-1:0] first_beat;
  logic [DW-1:0] keep;
  logic          take_word;

  // first beat captured at the mid-cycle fast edge and held to the core edge
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)        first_beat <= '0;
    else if (!hi_half) first_beat <= dq_in;
  end

  assign keep      = slice_mask(rd_en);
  assign take_word = dv_en && (rd_en != '0);

  // second beat taken straight from the bus at the core edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_rdata  <= '0;
      u_rvalid <= 1'b0;
    end else begin
      u_rvalid <= take_word;
      if (take_word) u_rdata <= {dq_in & keep, first_beat & keep};
    end
  end

  // R7
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_rvalid |-> $past(dv_en && (rd_en != '0)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !u_rvalid |-> $stable(u_rdata));
endmodule

// File: rtl/ddr_gearbox.sv
module ddr_gearbox
  import ddr_gb_pkg::*;
#(
  parameter  int UW     = GB_USER_W,
  parameter  int NSTRB  = GB_STROBES,
  parameter  int NSLICE = GB_SLICES,
  localparam int DW     = UW / 2,
  localparam int NLANE  = DW / GB_LANE_W
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic [UW-1:0]     u_wdata,
  input  logic [NLANE-1:0]  wr_lane_en,
  output logic [DW-1:0]     dq_out,
  output logic [NLANE-1:0]  dq_oe,
  output logic [NSTRB-1:0]  dqs_out,
  output logic [NSTRB-1:0]  dqs_oe,
  input  logic [DW-1:0]     dq_in,
  input  logic [NSLICE-1:0] rd_slice_en,
  input  logic              rd_dv_en,
  output logic [UW-1:0]     u_rdata,
  output logic              u_rvalid
);
  logic hi_half;

  ddr_gb_phase u_phase (
    .clk     (clk),
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .hi_half (hi_half)
  );

  ddr_gb_wr #(.UW(UW), .NSTRB(NSTRB)) u_wr (
    .clk     (clk),
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .hi_half (hi_half),
    .lane_en (wr_lane_en),
    .wdata   (u_wdata),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .dqs_out (dqs_out),
    .dqs_oe  (dqs_oe)
  );

  ddr_gb_rd #(.UW(UW), .NSLICE(NSLICE)) u_rd (
    .clk      (clk),
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .hi_half  (hi_half),
    .dq_in    (dq_in),
    .rd_en    (rd_slice_en),
    .dv_en    (rd_dv_en),
    .u_rdata  (u_rdata),
    .u_rvalid (u_rvalid)
  );
endmodule

// File: tb/ddr_gearbox_bench.sv
module ddr_gearbox_bench;
  logic         clk = 1'b0, clk2x = 1'b0, rst_n = 1'b0;
  logic [127:0] u_wdata = '0;
  logic [7:0]   wr_lane_en = '0;
  logic [63:0]  dq_out;
  logic [7:0]   dq_oe;
  logic [1:0]   dqs_out, dqs_oe;
  logic [63:0]  dq_in = '0;
  logic [3:0]   rd_slice_en = '0;
  logic         rd_dv_en = 1'b0;
  logic [127:0] u_rdata;
  logic         u_rvalid;

  ddr_gearbox u_ddr_gearbox (.*);

  // 125 MHz core clock, 250 MHz fast clock, made in one process
  always begin
    clk = 1'b1; clk2x = 1'b1; #2;
    clk2x = 1'b0; #2;
    clk2x = 1'b1; clk = 1'b0; #2;
    clk2x = 1'b0; #2;
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] strobes_for(input logic [7:0] ln);
    return {ln[7] | ln[6] | ln[5] | ln[4], ln[3] | ln[2] | ln[1] | ln[0]};
  endfunction

  function automatic logic [127:0] masked(input logic [127:0] w, input logic [3:0] en);
    logic [127:0] r = w;
    for (int s = 0; s < 4; s++)
      if (!en[s]) begin
        r[16*s +: 16]      = '0;
        r[64 + 16*s +: 16] = '0;
      end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // behavioural capture model on strobe 0 edges
  bit           cap_on = 0;
  logic [63:0]  cap_lo;
  logic [127:0] cap [0:63];
  logic [127:0] sent [0:63];
  int           ncap = 0, nsent = 0;

  always @(posedge dqs_out[0]) if (cap_on) cap_lo = dq_out;
  always @(negedge dqs_out[0])
    if (cap_on && ncap < 64) begin
      cap[ncap] = {dq_out, cap_lo};
      ncap++;
    end

  task automatic wr_single(input logic [127:0] w, input logic [7:0] ln);
    @(posedge clk); #1; wr_lane_en = ln; u_wdata = w;
    @(posedge clk); #1; wr_lane_en = '0;
    chk("R5 preamble oe", dqs_oe, strobes_for(ln));
    chk("R5 preamble low", dqs_out, 2'b00);
    chk("R3 idle before data", dq_oe, 8'h00);
    @(posedge clk); #1;
    chk("R3 lane oe", dq_oe, ln);
    chk("R2 first beat", dq_out, w[63:0]);
    #2; chk("R4 strobe high", dqs_out, strobes_for(ln));
    #2; chk("R2 second beat", dq_out, w[127:64]);
    #2; chk("R4 strobe low", dqs_out, 2'b00);
    @(posedge clk); #1;
    chk("R5 postamble oe", dqs_oe, strobes_for(ln));
    chk("R5 postamble low", dqs_out, 2'b00);
    chk("R3 released", dq_oe, 8'h00);
    @(posedge clk); #1;
    chk("R5 released", dqs_oe, 2'b00);
  endtask

  logic [127:0] held = '0;

  task automatic rd_burst(input logic [127:0] a, input logic [127:0] b,
                          input logic [3:0] en, input logic dv);
    logic v;
    string tag;
    v   = dv && (en != '0);
    tag = (en == 4'hF) ? "R6 word" : "R8 masked word";
    @(posedge clk); #1; rd_slice_en = en; rd_dv_en = dv; dq_in = a[63:0];
    #4; dq_in = a[127:64];
    @(posedge clk); #1;
    chk("R7 valid first", u_rvalid, v);
    if (v) held = masked(a, en);
    chk(v ? tag : "R9 hold", u_rdata, held);
    dq_in = b[63:0];
    #4; dq_in = b[127:64];
    @(posedge clk); #1; rd_slice_en = '0; rd_dv_en = 1'b0;
    chk("R7 valid second", u_rvalid, v);
    if (v) held = masked(b, en);
    chk(v ? tag : "R9 hold", u_rdata, held);
    @(posedge clk); #1;
    chk("R7 valid ends", u_rvalid, 1'b0);
    chk("R9 hold after", u_rdata, held);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #9;
    chk("R1 dq_oe", dq_oe, 8'h00);
    chk("R1 dqs_oe", dqs_oe, 2'b00);
    chk("R1 dqs", dqs_out, 2'b00);
    chk("R1 rvalid", u_rvalid, 1'b0);
    chk("R1 rdata", u_rdata, '0);
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;

    wr_single(128'h0123456789abcdef_fedcba9876543210, 8'hFF);
    wr_single(128'haaaa5555aaaa5555_3333cccc3333cccc, 8'h30);
    wr_single(128'h1, 8'h01);

    // random write bursts of two words, looped through the capture model
    cap_on = 1;
    for (int i = 0; i < 8; i++) begin
      logic [127:0] w0, w1;
      w0 = rnd128(); w1 = rnd128();
      @(posedge clk); #1; wr_lane_en = 8'hFF; u_wdata = w0;
      @(posedge clk); #1; u_wdata = w1;
      @(posedge clk); #1; wr_lane_en = '0;
      sent[nsent] = w0; sent[nsent+1] = w1; nsent += 2;
      repeat ($urandom % 3) @(posedge clk);
    end
    repeat (5) @(posedge clk);
    cap_on = 0;
    chk("R2 captured count", 128'(ncap), 128'(nsent));
    for (int i = 0; i < nsent; i++) chk("R2 loopback word", cap[i], sent[i]);

    // replay captured beats into the read side
    for (int i = 0; i < nsent; i += 2) begin
      rd_burst(cap[i], cap[i+1], 4'hF, 1'b1);
      chk("R6 reassembled vs sent", held, sent[i+1]);
    end

    // directed read corner cases
    rd_burst(rnd128(), rnd128(), 4'h5, 1'b1);
    rd_burst(rnd128(), rnd128(), 4'hF, 1'b0);
    rd_burst(rnd128(), rnd128(), 4'h0, 1'b1);
    rd_burst(rnd128(), rnd128(), 4'h8, 1'b1);

    // random reads
    for (int i = 0; i < 10; i++)
      rd_burst(rnd128(), rnd128(), 4'($urandom), ($urandom % 4) != 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    done = 1;
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule